// File: doc/BRIEF.md
# NH-Polynomial Hash Accumulator

This block computes one lane of a keyed universal hash over a message that arrives as a stream of 64-byte fragments. Each fragment is first compressed by an NH function. The function is built from four units, and each unit covers one 16-byte group of the fragment with four of the sixteen 32-bit key words. A 2-bit mode code sets how many of those groups count. The compressed fragment value is then folded into a running polynomial in a 60-bit key. That polynomial is evaluated in Horner form modulo the Mersenne prime 2^61−1.

To use the block, software or a controller loads the sixteen key words and the polynomial key with a one-cycle load strobe. It then presents fragments with a valid strobe. The block takes a fragment only while it is not busy, and it stays busy for several cycles while an iterative modular multiply runs. The fragment flagged as last raises the done flag, and the hash output then holds the final 61-bit value zero-extended to 64 bits. An empty message is presented as one all-zero fragment with mode 0.

Top module: `nhpoly_lane`

## Requirements
- R1: For one 16-byte group, the NH value is ((k0+m0) mod 2^32)·((k2+m2) mod 2^32) + ((k1+m1) mod 2^32)·((k3+m3) mod 2^32). Fragment word w is `frag_data[32w+31:32w]`, which is the little-endian reading of bytes 4w..4w+3. Key word w is `key_words[32w+31:32w]`, and group g uses words 4g..4g+3.
- R2: A `frag_mode` code of c adds the NH values of groups 0 to c. Groups above c have no effect on the result.
- R3: The fragment value is ((sum of the selected group NH values mod 2^64) + `frag_tail`) mod 2^60, where `frag_tail` is the fragment byte length mod 16.
- R4: The running value h starts at 1. Each accepted fragment with value a sets h to (h·kP + a) mod (2^61−1). `hash_out` is h zero-extended to 64 bits and is always below 2^61−1.
- R5: The polynomial key kP is `poly_key[59:0]`. Bits 63:60 are ignored.
- R6: A fragment is accepted when `frag_valid` is high, `busy` is low and `key_load` is low. `busy` is then high for exactly 5 cycles with the default 16-bit multiplier digit (number of digits + 1), and fragment inputs presented during that time are ignored.
- R7: `hash_done` rises together with the update for the fragment flagged `frag_last`. It stays high, with `hash_out` unchanged, until the next accepted fragment or key load. It is never high while `busy` is high.
- R8: A fragment accepted while `hash_done` is high starts a new message from h = 1 and keeps the loaded keys.
- R9: `key_load` while idle stores the keys, sets h to 1 and clears `hash_done`. It wins over a `frag_valid` in the same cycle, and that fragment is dropped. `key_load` while busy is ignored.
- R10: During reset, `busy` and `hash_done` are low and `hash_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_load | input | 1 | One-cycle strobe that loads both keys and restarts the hash |
| key_words | input | 512 | Sixteen 32-bit NH key words, word w at bits 32w+31:32w |
| poly_key | input | 64 | Polynomial key; the low 60 bits are used |
| frag_valid | input | 1 | Fragment present |
| frag_data | input | 512 | 64-byte fragment, byte j at bits 8j+7:8j |
| frag_mode | input | 2 | Index of the highest 16-byte group that is used |
| frag_tail | input | 4 | Fragment byte length mod 16 |
| frag_last | input | 1 | Fragment ends the message |
| busy | output | 1 | Multiply in progress; fragments and key loads are not taken |
| hash_out | output | 64 | Current hash value h, zero-extended |
| hash_done | output | 1 | The last fragment has been folded in |

## Verification
The same-cycle case is a key load and a fragment strobe arriving together in an idle cycle. The bench raises both in one cycle. It judges the result at the ports: `busy` must stay low on the next cycle, `hash_out` must read 1 and `hash_done` must be low, and a later fragment must hash under the new keys. A second overlap is a fragment strobe and a key load both presented while a multiply is running. The final hash is compared against a model that never saw that fragment or that key.

// File: rtl/nhpoly_pkg.sv
// Package nhpoly_pkg
// Shared widths and the prime constant for the NH-polynomial hash lane,
// plus the final modular add used when a fragment value joins the product.
// Assumes a 61-bit Mersenne modulus and a 60-bit polynomial key.
package nhpoly_pkg;

    localparam int WORD_W    = 32;
    localparam int GRP_WORDS = 4;
    localparam int N_GROUPS  = 4;
    localparam int GROUP_W   = WORD_W * GRP_WORDS;
    localparam int FRAG_W    = GROUP_W * N_GROUPS;
    localparam int KEYS_W    = FRAG_W;
    localparam int MODE_W    = $clog2(N_GROUPS);
    localparam int TAIL_W    = 4;
    localparam int NH_W      = 2 * WORD_W;
    localparam int PRIME_W   = 61;
    localparam int PKEY_W    = 60;
    localparam int HASH_W    = 64;

    localparam logic [PRIME_W-1:0] PRIME = '1;

    // Adds a fragment value (< 2^60) to a residue (< p) and reduces mod p.
    function automatic logic [PRIME_W-1:0] mod_add(
        input logic [PRIME_W-1:0] x,
        input logic [PKEY_W-1:0]  y
    );
        logic [PRIME_W:0] s;
        logic [PRIME_W:0] t;
        s = {1'b0, x} + {2'b00, y};
        t = {1'b0, s[PRIME_W-1:0]} + {{PRIME_W{1'b0}}, s[PRIME_W]};
        if (t >= {1'b0, PRIME}) begin
            t = t - {1'b0, PRIME};
        end
        return t[PRIME_W-1:0];
    endfunction

endpackage

// File: rtl/nh_unit.sv
// Module nh_unit
// One NH unit over a 16-byte group: two 32-bit key-plus-message sums are
// multiplied pairwise (word 0 with word 2, word 1 with word 3) and the two
// products are added modulo 2^64. Purely combinational.
// Assumes word w sits at bits 32w+31:32w of both inputs.
module nh_unit
    import nhpoly_pkg::*;
(
    input  logic [GROUP_W-1:0] msg,
    input  logic [GROUP_W-1:0] key,
    output logic [NH_W-1:0]    val
);

    logic [WORD_W-1:0] sum_w [GRP_WORDS];
    logic [NH_W-1:0]   prod_even;
    logic [NH_W-1:0]   prod_odd;

    // Word-wise key plus message, wrapping at 32 bits.
    always_comb begin
        for (int w = 0; w < GRP_WORDS; w++) begin
            sum_w[w] = msg[w*WORD_W +: WORD_W] + key[w*WORD_W +: WORD_W];
        end
    end

    // Cross products and their 64-bit wrapping sum.
    always_comb begin
        prod_even = {{WORD_W{1'b0}}, sum_w[0]} * {{WORD_W{1'b0}}, sum_w[2]};
        prod_odd  = {{WORD_W{1'b0}}, sum_w[1]} * {{WORD_W{1'b0}}, sum_w[3]};
        val       = prod_even + prod_odd;
    end

endmodule

// File: rtl/nh_compress.sv
// Module nh_compress
// Compresses one 64-byte fragment into a 60-bit value: N_GROUPS NH units
// run side by side, the mode code picks how many of them (from group 0
// upwards) are summed mod 2^64, the tail byte count is added and the result
// is truncated to 60 bits. Purely combinational.
// Assumes unused bytes of a short fragment are already zero.
module nh_compress
    import nhpoly_pkg::*;
(
    input  logic [FRAG_W-1:0] frag,
    input  logic [KEYS_W-1:0] keys,
    input  logic [MODE_W-1:0] mode,
    input  logic [TAIL_W-1:0] tail,
    output logic [PKEY_W-1:0] value
);

    logic [NH_W-1:0] unit_val [N_GROUPS];
    logic [NH_W-1:0] grp_sum;
    logic [NH_W-1:0] with_tail;
    logic [NH_W-PKEY_W-1:0] unused_top;

    // One NH unit for each 16-byte group.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_unit
        nh_unit u_nh (
            .msg (frag[g*GROUP_W +: GROUP_W]),
            .key (keys[g*GROUP_W +: GROUP_W]),
            .val (unit_val[g])
        );
    end

    // Sum the units selected by the mode code, wrapping at 64 bits.
    always_comb begin
        grp_sum = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (g <= int'(mode)) begin
                grp_sum = grp_sum + unit_val[g];
            end
        end
    end

    // Add the tail length and keep the low 60 bits.
    always_comb begin
        with_tail = grp_sum + {{(NH_W-TAIL_W){1'b0}}, tail};
        value     = with_tail[PKEY_W-1:0];
    end

    assign unused_top = with_tail[NH_W-1:PKEY_W];

endmodule

// File: rtl/modp_mul.sv
// Module modp_mul
// Iterative multiply modulo 2^61-1. The 60-bit key is walked DIGIT_W bits
// at a time from the most significant digit; each cycle the accumulator is
// shifted by one digit, the residue times the digit is added, and the sum
// is folded once above bit 61 and conditionally reduced by the prime.
// Assumes start is raised only while idle. fin pulses one cycle after the
// last digit step, with prod valid from then until the next start.
module modp_mul
    import nhpoly_pkg::*;
#(
    parameter int DIGIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PRIME_W-1:0] op_h,
    input  logic [PKEY_W-1:0]  op_k,
    output logic [PRIME_W-1:0] prod,
    output logic               fin
);

    localparam int NDIG   = (PKEY_W + DIGIT_W - 1) / DIGIT_W;
    localparam int KP_PAD = NDIG * DIGIT_W;
    localparam int CNT_W  = $clog2(NDIG + 1);
    localparam int STEP_W = PRIME_W + DIGIT_W + 1;
    localparam int PP_W   = PRIME_W + DIGIT_W;

    logic [KP_PAD-1:0]  kreg_q;
    logic [PRIME_W-1:0] acc_q;
    logic [PRIME_W-1:0] h_q;
    logic               active_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               fin_q;

    logic [DIGIT_W-1:0] digit;
    logic [PP_W-1:0]    partial;
    logic [STEP_W-1:0]  shifted;
    logic [PRIME_W-1:0] acc_next;

    // One fold of the bits above the prime width, then one subtraction.
    function automatic logic [PRIME_W-1:0] fold_step(input logic [STEP_W-1:0] x);
        logic [PRIME_W:0] s;
        s = (PRIME_W+1)'(x[PRIME_W-1:0]) + (PRIME_W+1)'(x[STEP_W-1:PRIME_W]);
        if (s >= (PRIME_W+1)'(PRIME)) begin
            s = s - (PRIME_W+1)'(PRIME);
        end
        return s[PRIME_W-1:0];
    endfunction

    // Digit step: acc * 2^DIGIT_W + h * digit, reduced.
    always_comb begin
        digit    = kreg_q[KP_PAD-1 -: DIGIT_W];
        partial  = {{DIGIT_W{1'b0}}, h_q} * {{PRIME_W{1'b0}}, digit};
        shifted  = {1'b0, acc_q, {DIGIT_W{1'b0}}};
        acc_next = fold_step(shifted + {1'b0, partial});
    end

    // Sequencer: load on start, step NDIG times, then pulse fin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kreg_q   <= '0;
            acc_q    <= '0;
            h_q      <= '0;
            active_q <= 1'b0;
            cnt_q    <= '0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                kreg_q   <= KP_PAD'(op_k);
                acc_q    <= '0;
                h_q      <= op_h;
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (active_q) begin
                acc_q  <= acc_next;
                kreg_q <= kreg_q << DIGIT_W;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(NDIG - 1)) begin
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end
            end
        end
    end

    assign prod = acc_q;
    assign fin  = fin_q;

endmodule

// File: rtl/nhpoly_lane.sv
// Module nhpoly_lane
// One lane of the NH-polynomial hash. It holds the NH key words and the
// 60-bit polynomial key, compresses each accepted fragment, and updates
// h <- (h * kP + a) mod (2^61-1) through an iterative multiplier. While the
// multiply runs the lane is busy and ignores fragments and key loads.
// Assumes keys are loaded before the first fragment of a message.
module nhpoly_lane
    import nhpoly_pkg::*;
#(
    parameter int DIGIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_load,
    input  logic [KEYS_W-1:0] key_words,
    input  logic [63:0]       poly_key,
    input  logic              frag_valid,
    input  logic [FRAG_W-1:0] frag_data,
    input  logic [MODE_W-1:0] frag_mode,
    input  logic [TAIL_W-1:0] frag_tail,
    input  logic              frag_last,
    output logic              busy,
    output logic [HASH_W-1:0] hash_out,
    output logic              hash_done
);

    logic [KEYS_W-1:0]  key_q;
    logic [PKEY_W-1:0]  kp_q;
    logic [PRIME_W-1:0] h_q;
    logic [PKEY_W-1:0]  a_q;
    logic               last_q;
    logic               busy_q;
    logic               done_q;

    logic [PKEY_W-1:0]  frag_val;
    logic [PRIME_W-1:0] seed;
    logic [PRIME_W-1:0] mul_prod;
    logic               mul_fin;
    logic               accept;
    logic               load;
    logic [3:0]         unused_pk;

    // Handshake: key load has priority; nothing is taken while busy.
    assign load   = key_load && !busy_q;
    assign accept = frag_valid && !busy_q && !key_load;

    // A finished message restarts from h = 1 on its next fragment.
    assign seed = done_q ? {{(PRIME_W-1){1'b0}}, 1'b1} : h_q;

    nh_compress u_nh (
        .frag  (frag_data),
        .keys  (key_q),
        .mode  (frag_mode),
        .tail  (frag_tail),
        .value (frag_val)
    );

    modp_mul #(.DIGIT_W(DIGIT_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .op_h  (seed),
        .op_k  (kp_q),
        .prod  (mul_prod),
        .fin   (mul_fin)
    );

    // Lane state: key storage, fragment capture and the hash update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            kp_q   <= '0;
            h_q    <= {{(PRIME_W-1){1'b0}}, 1'b1};
            a_q    <= '0;
            last_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (load) begin
            key_q  <= key_words;
            kp_q   <= poly_key[PKEY_W-1:0];
            h_q    <= {{(PRIME_W-1){1'b0}}, 1'b1};
            done_q <= 1'b0;
        end else if (accept) begin
            a_q    <= frag_val;
            last_q <= frag_last;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q && mul_fin) begin
            h_q    <= mod_add(mul_prod, a_q);
            busy_q <= 1'b0;
            done_q <= last_q;
        end
    end

    assign unused_pk = poly_key[63:PKEY_W];
    assign busy      = busy_q;
    assign hash_done = done_q;
    assign hash_out  = {{(HASH_W-PRIME_W){1'b0}}, h_q};

endmodule

// File: rtl/nhpoly_lane_chk.sv
// Module nhpoly_lane_chk
// Port-level properties of the hash lane, attached by bind. A run-length
// counter bounds the busy window instead of a parameter-sized delay.
// Assumes the default digit width of the lane it is bound to.
module nhpoly_lane_chk #(
    parameter int DIGIT_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frag_valid,
    input logic        key_load,
    input logic        busy,
    input logic        hash_done,
    input logic [63:0] hash_out
);

    localparam int NDIG = (60 + DIGIT_W - 1) / DIGIT_W;
    localparam logic [63:0] PRIME64 = 64'h1FFF_FFFF_FFFF_FFFF;

    logic [7:0] run_q;
    logic [7:0] run_len;

    // Length of the current busy run including this cycle.
    assign run_len = busy ? run_q + 8'd1 : 8'd0;

    // Track busy run length.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_len;
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !busy && !key_load) |=> busy) else $error("accept without busy"); // R6
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= 8'(NDIG + 1)) else $error("busy too long"); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hash_done |-> !busy) else $error("done while busy"); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy) && !$past(key_load)) |-> $stable(hash_out)) else $error("hash moved while idle"); // R7
    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && !busy) |=> (hash_out == 64'd1 && !hash_done)) else $error("load did not restart"); // R9
    AST_BELOW_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        hash_out < PRIME64) else $error("hash not reduced"); // R4

endmodule

bind nhpoly_lane nhpoly_lane_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frag_valid (frag_valid),
    .key_load   (key_load),
    .busy       (busy),
    .hash_done  (hash_done),
    .hash_out   (hash_out)
);

// File: tb/nhpoly_lane_test.sv
module nhpoly_lane_test;

    localparam logic [127:0] P128 = {67'd0, 61'h1FFF_FFFF_FFFF_FFFF};

    typedef struct packed {
        logic [31:0] w0, w1, w2, w3;
        logic [1:0]  mode;
        logic [3:0]  tail;
        logic [63:0] pkey;
        logic [63:0] exp;
    } vec_t;

    // Keys all zero, group pattern replicated in all four groups.
    localparam vec_t TBL [7] = '{
        '{32'd1, 32'd2, 32'd3, 32'd4, 2'd0, 4'd0, 64'd0, 64'd11},                      // R1 one group
        '{32'd1, 32'd2, 32'd3, 32'd4, 2'd3, 4'd5, 64'd0, 64'd49},                      // R2 R3 four groups + tail
        '{32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 32'd0, 2'd1, 4'd0, 64'd0, 64'h0FFFFFFC00000002}, // R3 wrap 2^64, mask 2^60
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd3, 4'd15, 64'd0, 64'h0FFFFFF000000017}, // R3
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd3, 4'd15, 64'h0FFFFFFFFFFFFFFF, 64'h1FFFFFF000000016}, // R4
        '{32'd1, 32'd2, 32'd3, 32'd4, 2'd0, 4'd0, 64'hF000000000000003, 64'd14},       // R5 key masked
        '{32'd1, 32'd2, 32'd3, 32'd4, 2'd2, 4'd1, 64'd0, 64'd34}                       // R2 three groups
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         key_load;
    logic [511:0] key_words;
    logic [63:0]  poly_key;
    logic         frag_valid;
    logic [511:0] frag_data;
    logic [1:0]   frag_mode;
    logic [3:0]   frag_tail;
    logic         frag_last;
    logic         busy;
    logic [63:0]  hash_out;
    logic         hash_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nhpoly_lane uut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_words(key_words),
        .poly_key(poly_key), .frag_valid(frag_valid), .frag_data(frag_data),
        .frag_mode(frag_mode), .frag_tail(frag_tail), .frag_last(frag_last),
        .busy(busy), .hash_out(hash_out), .hash_done(hash_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [59:0] m_frag(input logic [511:0] d, input logic [511:0] k,
                                            input logic [1:0] mode, input logic [3:0] tail);
        logic [63:0] sum;
        logic [31:0] s [4];
        sum = 64'd0;
        for (int g = 0; g < 4; g++) begin
            if (g <= int'(mode)) begin
                for (int w = 0; w < 4; w++) begin
                    s[w] = d[(4*g+w)*32 +: 32] + k[(4*g+w)*32 +: 32];
                end
                sum = sum + {32'd0, s[0]} * {32'd0, s[2]} + {32'd0, s[1]} * {32'd0, s[3]};
            end
        end
        sum = sum + {60'd0, tail};
        return sum[59:0];
    endfunction

    function automatic logic [60:0] m_step(input logic [60:0] h, input logic [63:0] pk,
                                            input logic [59:0] a);
        logic [127:0] t;
        t = {67'd0, h} * {68'd0, pk[59:0]};
        t = (t + {68'd0, a}) % P128;
        return t[60:0];
    endfunction

    function automatic logic [511:0] mk_data(input int seed);
        logic [511:0] d;
        for (int j = 0; j < 16; j++) begin
            d[j*32 +: 32] = 32'hA5A5_0000 ^ (32'(j) * 32'd2654435761 + 32'(seed));
        end
        return d;
    endfunction

    task automatic do_load(input logic [511:0] k, input logic [63:0] pk);
        @(negedge clk);
        key_load = 1'b1; key_words = k; poly_key = pk;
        @(negedge clk);
        key_load = 1'b0;
    endtask

    task automatic send(input logic [511:0] d, input logic [1:0] m, input logic [3:0] t,
                        input logic last, output int bcount);
        @(negedge clk);
        frag_valid = 1'b1; frag_data = d; frag_mode = m; frag_tail = t; frag_last = last;
        @(negedge clk);
        frag_valid = 1'b0;
        bcount = 0;
        while (busy) begin
            bcount++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [511:0] ka, kb;
        logic [63:0]  pa;
        logic [60:0]  h;
        logic [63:0]  held;
        int bc;

        rst_n = 1'b0; key_load = 1'b0; key_words = '0; poly_key = '0;
        frag_valid = 1'b0; frag_data = '0; frag_mode = '0; frag_tail = '0; frag_last = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset busy", {63'd0, busy}, 64'd0);
        chk("R10 reset done", {63'd0, hash_done}, 64'd0);
        chk("R10 reset hash", hash_out, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of hand-computed single-fragment vectors.
        for (int i = 0; i < 7; i++) begin
            do_load('0, TBL[i].pkey);
            send({4{TBL[i].w3, TBL[i].w2, TBL[i].w1, TBL[i].w0}}, TBL[i].mode, TBL[i].tail, 1'b1, bc);
            chk("R3 table hash", hash_out, TBL[i].exp);
            chk("R7 table done", {63'd0, hash_done}, 64'd1);
        end

        // R1: key plus message wraps at 32 bits.
        ka = '0; ka[31:0] = 32'hFFFF_FFFF;
        do_load(ka, 64'd0);
        send({384'd0, 32'd0, 32'd5, 32'd0, 32'd2}, 2'd0, 4'd0, 1'b1, bc);
        chk("R1 word wrap", hash_out, 64'd5);

        // Multi-fragment message with full keys.
        for (int i = 0; i < 16; i++) ka[i*32 +: 32] = 32'(i + 1) * 32'h9E37_79B9;
        pa = 64'h0F3C_5A69_1234_ABCD;
        do_load(ka, pa);
        h = 61'd1;
        send(mk_data(1), 2'd3, 4'd0, 1'b0, bc);
        h = m_step(h, pa, m_frag(mk_data(1), ka, 2'd3, 4'd0));
        chk("R6 busy length", 64'(bc), 64'd5);
        chk("R4 first fragment", hash_out, {3'd0, h});
        chk("R7 no done mid message", {63'd0, hash_done}, 64'd0);

        // Second fragment with junk fragment and key load during busy.
        @(negedge clk);
        frag_valid = 1'b1; frag_data = mk_data(2); frag_mode = 2'd3; frag_tail = 4'd0; frag_last = 1'b0;
        @(negedge clk);
        frag_data = mk_data(99); frag_last = 1'b1;
        key_load = 1'b1; key_words = '1; poly_key = 64'd7;
        @(negedge clk);
        @(negedge clk);
        frag_valid = 1'b0; key_load = 1'b0;
        while (busy) @(negedge clk);
        h = m_step(h, pa, m_frag(mk_data(2), ka, 2'd3, 4'd0));
        chk("R6 busy inputs ignored", hash_out, {3'd0, h});
        chk("R9 busy load ignored done", {63'd0, hash_done}, 64'd0);

        send(mk_data(3), 2'd1, 4'd7, 1'b1, bc);
        h = m_step(h, pa, m_frag(mk_data(3), ka, 2'd1, 4'd7));
        chk("R4 three fragments", hash_out, {3'd0, h});
        chk("R7 done at last", {63'd0, hash_done}, 64'd1);

        held = hash_out;
        repeat (4) @(negedge clk);
        chk("R7 hash held", hash_out, held);
        chk("R7 done held", {63'd0, hash_done}, 64'd1);

        // R8: next fragment after done restarts from 1.
        send(mk_data(4), 2'd2, 4'd3, 1'b1, bc);
        h = m_step(61'd1, pa, m_frag(mk_data(4), ka, 2'd2, 4'd3));
        chk("R8 restart after done", hash_out, {3'd0, h});

        // R9: key load and fragment in the same idle cycle.
        for (int i = 0; i < 16; i++) kb[i*32 +: 32] = 32'hC001_0000 + 32'(i * 977);
        @(negedge clk);
        key_load = 1'b1; key_words = kb; poly_key = 64'h0ABC_DEF0_1357_9BDF;
        frag_valid = 1'b1; frag_data = mk_data(5); frag_mode = 2'd3; frag_last = 1'b1;
        @(negedge clk);
        key_load = 1'b0; frag_valid = 1'b0;
        chk("R9 fragment dropped busy", {63'd0, busy}, 64'd0);
        chk("R9 load sets h", hash_out, 64'd1);
        chk("R9 load clears done", {63'd0, hash_done}, 64'd0);
        send(mk_data(6), 2'd0, 4'd9, 1'b1, bc);
        h = m_step(61'd1, 64'h0ABC_DEF0_1357_9BDF, m_frag(mk_data(6), kb, 2'd0, 4'd9));
        chk("R9 new keys used", hash_out, {3'd0, h});

        // R9: load in the middle of a message restarts h.
        send(mk_data(7), 2'd3, 4'd0, 1'b0, bc);
        do_load(kb, 64'h0ABC_DEF0_1357_9BDF);
        chk("R9 mid message load", hash_out, 64'd1);

        // R4: empty message as one zero fragment, mode 0.
        send('0, 2'd0, 4'd0, 1'b1, bc);
        h = m_step(61'd1, 64'h0ABC_DEF0_1357_9BDF, m_frag('0, kb, 2'd0, 4'd0));
        chk("R4 empty message", hash_out, {3'd0, h});

        // R10: reset during a multiply.
        @(negedge clk);
        frag_valid = 1'b1; frag_data = mk_data(8); frag_last = 1'b1;
        @(negedge clk);
        frag_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset clears busy", {63'd0, busy}, 64'd0);
        chk("R10 reset hash", hash_out, 64'd1);
        repeat (6) @(negedge clk);
        chk("R10 no late done", {63'd0, hash_done}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule